// File: doc/BRIEF.md
# Two-Action Arming Safety Controller

This block decides, cycle by cycle, whether a weapon firing path may be enabled and whether the brakes may be released. It runs two identical copies of the arming state machine side by side. The final fire-enable is the AND of both copies, and so is the brake-release. Any disagreement between the copies, sampled on the millisecond tick, is treated as a fault.

Arming needs two separate actions. The physical key must move into its armed position, and a software arm command must rise. The second action must come within a bounded number of millisecond ticks after the first, and either order is allowed. A maintenance lockout key position overrides every software request. A safe-state trigger from the watchdog, or any detected fault, forces the outputs into a latched safe state. Only an operator reset, given with the key in the safe position and no fault source active, brings the block out of that state.

The key input is checked for continuity on a fixed tick period, and an open reading at a check instant is a fault. Each redundant channel receives its own copy of the software arm line.

Top module: `arm_ctrl_top`

## Requirements
- R1: After power-on reset, `fire_en_o`, `brake_rel_o` and `fault_o` are all 0.
- R2: The key code is 2'b01 safe, 2'b10 armed, 2'b11 lockout and 2'b00 open. An operator reset is accepted only when the key is safe, no `fault_src_i` bit is set and `safe_trig_i` is low. When accepted, `brake_rel_o` goes to 1 and `fault_o` goes to 0 one clock later. Otherwise the reset has no effect.
- R3: If the key goes to armed and then `sw_arm_i` rises while the key is still armed, `fire_en_o` goes to 1 one clock after the rise. The key alone does not enable firing.
- R4: If `sw_arm_i` rises while the key is not armed and the key then reaches armed, `fire_en_o` goes to 1 one clock after the key reaches armed. The software command alone does not enable firing.
- R5: The second action is accepted only if fewer than WINDOW_MS ticks have passed since the first action. After WINDOW_MS ticks, the pending action is discarded in either order.
- R6: While the key is in lockout, `fire_en_o` is 0 and arm commands are ignored, including a command pending from before the lockout. Leaving lockout for armed counts as a fresh key action.
- R7: When the key leaves armed, `fire_en_o` drops one clock later. Re-arming then needs a new key action and a new rise of `sw_arm_i`.
- R8: When `safe_trig_i` is high, `fire_en_o` and `brake_rel_o` are 0 one clock later. They stay 0 after the trigger drops, until an accepted operator reset. `fire_en_o` is never 1 while `brake_rel_o` is 0.
- R9: Any set `fault_src_i` bit makes `fault_o` 1 and both `fire_en_o` and `brake_rel_o` 0 one clock later. The fault stays latched after the source clears, until an accepted operator reset.
- R10: The key code is sampled every CHECK_TICKS ticks. An open code (2'b00) at a sample sets `fault_o`.
- R11: If the two channels disagree on fire-enable or brake-release on a tick, `fault_o` is set one clock later. While they disagree, `fire_en_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle millisecond tick |
| key_code_i | input | 2 | Decoded key position |
| sw_arm_i | input | NCH | Software arm command, one copy per channel |
| safe_trig_i | input | 1 | Safe-state trigger from watchdog module |
| fault_src_i | input | NSRC | Internal fault flags |
| op_reset_i | input | 1 | Operator reset request |
| fire_en_o | output | 1 | Firing enable, AND of channels |
| brake_rel_o | output | 1 | Brake release, AND of channels |
| fault_o | output | 1 | Latched fault status |

## Verification
Arming is tried in both orders. In each order the second action lands either one tick inside the window or exactly at its end, which separates a correct window count from an off-by-one or a missing timeout. Arming is also tried with the software line held across a key cycle, with lockout entered before and during a pending command, and with channel copies driven apart. These cases show that only genuine rising actions count and that the channels are really cross-checked. Operator resets are issued with the key armed, with a source still active and with the trigger still high, and each must be refused before the valid one is accepted.

// File: rtl/arm_pkg.sv
package arm_pkg;
  typedef enum logic [1:0] {
    KEY_OPEN  = 2'b00,
    KEY_SAFE  = 2'b01,
    KEY_ARMED = 2'b10,
    KEY_LOCK  = 2'b11
  } key_pos_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_SW,
    ST_WAIT_KEY,
    ST_ARMED
  } arm_st_e;
endpackage

// File: rtl/arm_key_mon.sv
module arm_key_mon
  import arm_pkg::*;
#(
  parameter int unsigned CHECK_TICKS = 10
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  key_pos_e key_i,
  output logic     key_fault_o
);
  localparam int unsigned CW = (CHECK_TICKS > 1) ? $clog2(CHECK_TICKS) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_chk;

  assign at_chk = tick_i && (cnt_q == CW'(CHECK_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= at_chk ? '0 : cnt_q + 1'b1;
  end

  assign key_fault_o = at_chk && (key_i == KEY_OPEN);
endmodule

// File: rtl/arm_channel.sv
module arm_channel
  import arm_pkg::*;
#(
  parameter int unsigned WINDOW_MS = 2000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  key_pos_e key_i,
  input  logic     sw_arm_i,
  input  logic     trip_i,
  input  logic     release_i,
  output logic     fire_en_o,
  output logic     brake_rel_o
);
  localparam int unsigned CW = $clog2(WINDOW_MS + 1);

  arm_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          safe_q, key_armed_q, sw_q;
  logic          key_armed, key_rise, sw_rise, expire, inhibit;

  assign key_armed = (key_i == KEY_ARMED);
  assign key_rise  = key_armed && !key_armed_q;
  assign sw_rise   = sw_arm_i && !sw_q;
  assign expire    = tick_i && (cnt_q == CW'(WINDOW_MS - 1));
  assign inhibit   = trip_i || safe_q || (key_i == KEY_LOCK);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if ((st_q == ST_WAIT_SW || st_q == ST_WAIT_KEY) && tick_i) cnt_d = cnt_q + 1'b1;
    if (inhibit) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (key_rise && sw_rise)       st_d = ST_ARMED;
          else if (key_rise)             st_d = ST_WAIT_SW;
          else if (sw_rise && !key_armed) st_d = ST_WAIT_KEY;
        end
        ST_WAIT_SW: begin
          if (!key_armed)   st_d = ST_IDLE;
          else if (sw_rise) st_d = ST_ARMED;
          else if (expire)  st_d = ST_IDLE;
        end
        ST_WAIT_KEY: begin
          if (key_rise)    st_d = ST_ARMED;
          else if (expire) st_d = ST_IDLE;
        end
        ST_ARMED: begin
          if (!key_armed) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      safe_q      <= 1'b1;
      key_armed_q <= 1'b0;
      sw_q        <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      key_armed_q <= key_armed;
      sw_q        <= sw_arm_i;
      if (trip_i)         safe_q <= 1'b1;
      else if (release_i) safe_q <= 1'b0;
    end
  end

  assign fire_en_o   = (st_q == ST_ARMED) && !safe_q;
  assign brake_rel_o = !safe_q;

  AST_ARMED_HAS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED) |-> key_armed_q); // R7
  AST_LOCK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_i == KEY_LOCK) |=> (st_q != ST_ARMED)); // R6
  AST_TRIP_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> (!fire_en_o && !brake_rel_o)); // R8
endmodule

// File: rtl/arm_fault_latch.sv
module arm_fault_latch
  import arm_pkg::*;
#(
  parameter int unsigned NSRC = 4,
  parameter int unsigned NCH  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [NSRC-1:0] src_i,
  input  logic            key_fault_i,
  input  key_pos_e        key_i,
  input  logic            safe_trig_i,
  input  logic            op_reset_i,
  input  logic [NCH-1:0]  fire_i,
  input  logic [NCH-1:0]  brake_i,
  output logic            fault_o,
  output logic            trip_o,
  output logic            release_o
);
  logic mism, fault_set, reset_ok, fault_q;

  // channels compared once per tick
  assign mism = tick_i && (((|fire_i) && !(&fire_i)) || ((|brake_i) && !(&brake_i)));
  assign fault_set = (|src_i) || key_fault_i || mism;
  assign reset_ok  = op_reset_i && (key_i == KEY_SAFE) && !(|src_i) && !safe_trig_i;
  assign release_o = reset_ok && !fault_set;
  assign trip_o    = fault_set || safe_trig_i || (fault_q && !release_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fault_q <= 1'b0;
    else if (fault_set) fault_q <= 1'b1;
    else if (release_o) fault_q <= 1'b0;
  end

  assign fault_o = fault_q;

  AST_SRC_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> fault_q); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !op_reset_i) |=> fault_q); // R9
  AST_MISMATCH_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ((|fire_i) && !(&fire_i))) |=> fault_q); // R11
endmodule

// File: rtl/arm_ctrl_top.sv
module arm_ctrl_top
  import arm_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned NSRC        = 4,
  parameter int unsigned WINDOW_MS   = 2000,
  parameter int unsigned CHECK_TICKS = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [1:0]      key_code_i,
  input  logic [NCH-1:0]  sw_arm_i,
  input  logic            safe_trig_i,
  input  logic [NSRC-1:0] fault_src_i,
  input  logic            op_reset_i,
  output logic            fire_en_o,
  output logic            brake_rel_o,
  output logic            fault_o
);
  key_pos_e       key;
  logic           key_fault, trip, release_ok;
  logic [NCH-1:0] ch_fire, ch_brake;

  assign key = key_pos_e'(key_code_i);

  arm_key_mon #(.CHECK_TICKS(CHECK_TICKS)) u_key_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .key_i       (key),
    .key_fault_o (key_fault)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    arm_channel #(.WINDOW_MS(WINDOW_MS)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .key_i       (key),
      .sw_arm_i    (sw_arm_i[c]),
      .trip_i      (trip),
      .release_i   (release_ok),
      .fire_en_o   (ch_fire[c]),
      .brake_rel_o (ch_brake[c])
    );
  end

  arm_fault_latch #(.NSRC(NSRC), .NCH(NCH)) u_fault (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .src_i       (fault_src_i),
    .key_fault_i (key_fault),
    .key_i       (key),
    .safe_trig_i (safe_trig_i),
    .op_reset_i  (op_reset_i),
    .fire_i      (ch_fire),
    .brake_i     (ch_brake),
    .fault_o     (fault_o),
    .trip_o      (trip),
    .release_o   (release_ok)
  );

  // both channels must agree to drive the actuators
  assign fire_en_o   = &ch_fire;
  assign brake_rel_o = &ch_brake;

  AST_FIRE_NEEDS_BRAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_en_o |-> brake_rel_o); // R8
  AST_CLEAR_KEY_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> ($past(key_code_i) == 2'b01)); // R2
endmodule

// File: tb/arm_ctrl_top_tb_top.sv
module arm_ctrl_top_tb_top;
  localparam int unsigned WIN  = 2000;
  localparam int unsigned CHK  = 10;
  localparam int unsigned NSRC = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tick = 1'b0;
  logic [1:0]      key = 2'b01;
  logic [1:0]      sw = 2'b00;
  logic            trig = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            op_rst = 1'b0;
  logic            fire_en_o, brake_rel_o, fault_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2 clk_i = ~clk_i;

  arm_ctrl_top #(
    .NCH(2), .NSRC(NSRC), .WINDOW_MS(WIN), .CHECK_TICKS(CHK)
  ) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .key_code_i  (key),
    .sw_arm_i    (sw),
    .safe_trig_i (trig),
    .fault_src_i (src),
    .op_reset_i  (op_rst),
    .fire_en_o   (fire_en_o),
    .brake_rel_o (brake_rel_o),
    .fault_o     (fault_o)
  );

  // expectation holds after the next rising edge
  task automatic expect_out(input logic fe, input logic br, input logic ft, input string tag);
    exp_q.push_back({fe, br, ft});
    tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk_i);
      tick = 1'b0;
      repeat (3) @(negedge clk_i);
    end
  endtask

  // monitor: compare one expectation per cycle, between edges
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({fire_en_o, brake_rel_o, fault_o} !== e) begin
          n_fail++;
          $display("FAIL %s: fire/brake/fault actual=%b expected=%b", t,
                   {fire_en_o, brake_rel_o, fault_o}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    expect_out(0, 0, 0, "R1 reset state");
    expect_out(0, 0, 0, "R1 idle after reset");

    // R2 operator reset gating
    key = 2'b10; op_rst = 1'b1;
    expect_out(0, 0, 0, "R2 reset refused with key armed");
    op_rst = 1'b0; key = 2'b01;
    expect_out(0, 0, 0, "R2 key back safe");
    op_rst = 1'b1;
    expect_out(0, 1, 0, "R2 reset accepted");
    op_rst = 1'b0;

    // R3 key then software
    key = 2'b10;
    expect_out(0, 1, 0, "R3 key alone");
    sw = 2'b11;
    expect_out(1, 1, 0, "R3 armed key first");

    // R7 disarm on key leaving armed, fresh sequence needed
    key = 2'b01;
    expect_out(0, 1, 0, "R7 disarm");
    key = 2'b10;
    expect_out(0, 1, 0, "R7 held sw not reused");
    ticks(3);
    expect_out(0, 1, 0, "R7 still disarmed");
    sw = 2'b00;
    expect_out(0, 1, 0, "R7 sw low");
    sw = 2'b11;
    expect_out(1, 1, 0, "R7 rearm fresh sw");

    // R4 software then key
    key = 2'b01; sw = 2'b00;
    expect_out(0, 1, 0, "R4 prep");
    sw = 2'b11;
    expect_out(0, 1, 0, "R4 sw alone");
    ticks(5);
    key = 2'b10;
    expect_out(1, 1, 0, "R4 armed sw first");

    // R5 window boundaries
    key = 2'b01; sw = 2'b00;
    expect_out(0, 1, 0, "R5 prep");
    key = 2'b10;
    expect_out(0, 1, 0, "R5 key first pending");
    ticks(WIN - 1);
    sw = 2'b11;
    expect_out(1, 1, 0, "R5 key first last tick inside");
    key = 2'b01; sw = 2'b00;
    expect_out(0, 1, 0, "R5 prep");
    key = 2'b10;
    expect_out(0, 1, 0, "R5 key first pending");
    ticks(WIN);
    sw = 2'b11;
    expect_out(0, 1, 0, "R5 key first expired");
    key = 2'b01; sw = 2'b00;
    expect_out(0, 1, 0, "R5 prep");
    sw = 2'b11;
    expect_out(0, 1, 0, "R5 sw first pending");
    ticks(WIN - 1);
    key = 2'b10;
    expect_out(1, 1, 0, "R5 sw first last tick inside");
    key = 2'b01; sw = 2'b00;
    expect_out(0, 1, 0, "R5 prep");
    sw = 2'b11;
    expect_out(0, 1, 0, "R5 sw first pending");
    ticks(WIN);
    key = 2'b10;
    expect_out(0, 1, 0, "R5 sw first expired");

    // R6 lockout
    key = 2'b01; sw = 2'b00;
    expect_out(0, 1, 0, "R6 prep");
    key = 2'b11;
    expect_out(0, 1, 0, "R6 lockout");
    sw = 2'b11;
    expect_out(0, 1, 0, "R6 sw under lockout");
    key = 2'b10;
    expect_out(0, 1, 0, "R6 sw from lockout ignored");
    sw = 2'b00;
    expect_out(0, 1, 0, "R6 sw low");
    sw = 2'b11;
    expect_out(1, 1, 0, "R6 lockout exit is key action");
    key = 2'b11;
    expect_out(0, 1, 0, "R6 lockout disarms");
    key = 2'b01; sw = 2'b00;
    expect_out(0, 1, 0, "R6 prep");
    sw = 2'b11;
    expect_out(0, 1, 0, "R6 sw pending");
    key = 2'b11;
    expect_out(0, 1, 0, "R6 lockout during pending");
    key = 2'b10;
    expect_out(0, 1, 0, "R6 pending sw cancelled");

    // R8 safe-state trigger
    key = 2'b01; sw = 2'b00;
    expect_out(0, 1, 0, "R8 prep");
    key = 2'b10;
    expect_out(0, 1, 0, "R8 prep");
    sw = 2'b11;
    expect_out(1, 1, 0, "R8 armed");
    trig = 1'b1;
    expect_out(0, 0, 0, "R8 trigger safes");
    trig = 1'b0;
    expect_out(0, 0, 0, "R8 latched");
    op_rst = 1'b1;
    expect_out(0, 0, 0, "R8 reset refused key armed");
    op_rst = 1'b0; key = 2'b01;
    expect_out(0, 0, 0, "R8 key safe");
    op_rst = 1'b1; trig = 1'b1;
    expect_out(0, 0, 0, "R8 reset refused trigger high");
    trig = 1'b0;
    expect_out(0, 1, 0, "R8 released");
    op_rst = 1'b0;

    // R9 fault sources
    key = 2'b10;
    expect_out(0, 1, 0, "R9 prep");
    sw = 2'b00;
    expect_out(0, 1, 0, "R9 prep");
    sw = 2'b11;
    expect_out(1, 1, 0, "R9 armed");
    src = 4'b0100;
    expect_out(0, 0, 1, "R9 fault latched");
    key = 2'b01; op_rst = 1'b1;
    expect_out(0, 0, 1, "R9 reset refused source active");
    src = '0;
    expect_out(0, 1, 0, "R9 cleared");
    op_rst = 1'b0;
    src = 4'b0001;
    expect_out(0, 0, 1, "R9 pulse fault");
    src = '0;
    expect_out(0, 0, 1, "R9 stays latched");
    op_rst = 1'b1;
    expect_out(0, 1, 0, "R9 cleared by reset");
    op_rst = 1'b0;

    // R10 key continuity
    key = 2'b00;
    ticks(CHK);
    expect_out(0, 0, 1, "R10 open key fault");
    key = 2'b01; op_rst = 1'b1;
    expect_out(0, 1, 0, "R10 cleared");
    op_rst = 1'b0;

    // R11 channel disagreement
    key = 2'b10; sw = 2'b00;
    expect_out(0, 1, 0, "R11 prep");
    sw = 2'b01;
    expect_out(0, 1, 0, "R11 single channel no fire");
    ticks(1);
    expect_out(0, 0, 1, "R11 mismatch fault");
    sw = 2'b00; key = 2'b01; op_rst = 1'b1;
    expect_out(0, 1, 0, "R11 cleared");
    op_rst = 1'b0;

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule